// File: doc/BRIEF.md
# Ethernet destination address filter

This block decides whether a received Ethernet frame should be kept. It watches the six destination-address bytes as they arrive, one byte per cycle. The first byte is marked by a start-of-frame strobe. While the bytes arrive, it runs a CRC-32 over them and collects the address. On the last byte it makes one accept-or-drop decision. The decision uses an exact compare against the station address, a 64-bin multicast hash table and a set of mode bits.

The hash bin is taken from the top six bits of the CRC register once all six bytes have been folded in. A set of static configuration inputs selects the filtering policy:

- promiscuous;
- pass every multicast;
- hash multicast with exact unicast;
- hash for unicast too;
- invert the filter result.

The verdict and a one-cycle valid strobe appear one clock after the sixth byte.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset `dec_valid` is low, and address bytes presented without a preceding `frm_start` never produce a decision.
- R2: The CRC register is preset to all ones and uses polynomial 0x04C11DB7. Each byte is shifted in least significant bit first, and there is no final inversion. The bin index is register bits 31:26. Index bit 5 picks `hash_hi` (1) or `hash_lo` (0), and index bits 4:0 pick the bit within that word.
- R3: `dec_valid` pulses high for exactly one cycle, in the cycle after the sixth address byte. Further bytes are ignored until the next `frm_start`.
- R4: A byte presented with `frm_start` is always taken as byte 0 of a new address, and any partial CRC and byte count are discarded.
- R5: The all-ones broadcast address is always accepted.
- R6: With `mode_promisc` set, every address is accepted, and the inversion of R11 does not apply.
- R7: An address is multicast when bit 0 of its first byte is 1. With `mode_all_mcast` set, every multicast address passes the filter path.
- R8: With `mode_hash_mix` set, a unicast address passes only on an exact station match, and a multicast address passes only if its hash bit is set.
- R9: With no mode bits set, only an exact station match (or broadcast) is accepted, and other multicast addresses are dropped. The first byte on the wire corresponds to `station_addr[7:0]`, and byte i corresponds to bits 8i+7:8i.
- R10: With `mode_hash_uni` set, unicast addresses pass on their hash bit instead of the exact compare, and multicast addresses also use the hash.
- R11: With `mode_invert` set, the filter-path result is inverted for every non-broadcast address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Marks byte 0 of a destination address |
| byte_vld | input | 1 | `byte_in` carries an address byte |
| byte_in | input | 8 | Address byte |
| station_addr | input | 48 | Own station address, first wire byte in bits 7:0 |
| hash_lo | input | 32 | Hash bins 0 to 31 |
| hash_hi | input | 32 | Hash bins 32 to 63 |
| mode_promisc | input | 1 | Accept everything |
| mode_all_mcast | input | 1 | Pass all multicast |
| mode_hash_mix | input | 1 | Hash multicast, exact unicast |
| mode_hash_uni | input | 1 | Hash unicast as well |
| mode_invert | input | 1 | Invert filter-path result |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Verdict, meaningful with `dec_valid` |

## Verification
The block has no parameters, so the bench builds it as is. Because there are only five mode bits, all 32 mode combinations can be swept against unicast-hit, unicast-miss, two multicast and broadcast addresses. The bench also walks 64 multicast addresses, loading a hash table with only the predicted bin set and then with only that bin clear, so every bin position and the word split are covered. It predicts the bins with a reflected, right-shifting CRC that it computes itself.

// File: rtl/dst_addr_filter.sv
module dst_addr_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_start,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  input  logic [47:0] station_addr,
  input  logic [31:0] hash_lo,
  input  logic [31:0] hash_hi,
  input  logic        mode_promisc,
  input  logic        mode_all_mcast,
  input  logic        mode_hash_mix,
  input  logic        mode_hash_uni,
  input  logic        mode_invert,
  output logic        dec_valid,
  output logic        dec_accept
);
  localparam logic [31:0] POLY = 32'h04C11DB7;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  logic [31:0] crc_q;
  logic [39:0] addr_q;
  logic [2:0]  cnt_q;

  wire take_first = frm_start & byte_vld;
  wire take_next  = byte_vld & ~frm_start & (cnt_q != 3'd0) & (cnt_q < 3'd6);
  wire last_byte  = take_next & (cnt_q == 3'd5);

  wire [31:0] crc_nx = crc_byte(take_first ? 32'hFFFF_FFFF : crc_q, byte_in);
  wire [47:0] full   = {byte_in, addr_q};
  wire [5:0]  bin    = crc_nx[31:26];
  wire        hash_hit = bin[5] ? hash_hi[bin[4:0]] : hash_lo[bin[4:0]];

  wire is_bcast = &full;
  wire is_mcast = full[0];
  wire exact    = (full == station_addr);
  wire path     = is_mcast ? (mode_all_mcast | ((mode_hash_mix | mode_hash_uni) & hash_hit))
                           : (mode_hash_uni ? hash_hit : exact);
  wire verdict  = is_bcast | mode_promisc | (path ^ mode_invert);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q      <= '1;
      addr_q     <= '0;
      cnt_q      <= '0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      if (take_first) begin
        crc_q  <= crc_nx;
        addr_q <= {32'b0, byte_in};
        cnt_q  <= 3'd1;
      end else if (take_next) begin
        crc_q  <= crc_nx;
        addr_q <= addr_q | ({32'b0, byte_in} << {cnt_q, 3'b000});
        cnt_q  <= cnt_q + 3'd1;
      end
      dec_valid  <= last_byte;
      dec_accept <= last_byte & verdict;
    end
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && byte_vld) |=> (cnt_q == 3'd1));

  assert_promisc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && mode_promisc) |=> (dec_valid && dec_accept));

  assert_bcast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_byte && ({byte_in, addr_q} == 48'hFFFF_FFFF_FFFF)) |=> dec_accept);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 3'd0) |=> !dec_valid);

  assert_accept_qual_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);
endmodule

// File: tb/dst_addr_filter_bench.sv
`timescale 1ns/1ps
module dst_addr_filter_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic frm_start = 0, byte_vld = 0;
  logic [7:0] byte_in = 0;
  logic [47:0] station_addr = 48'h6B_4F_9E_3A_1C_02;
  logic [31:0] hash_lo = 32'hA5C3_0F96, hash_hi = 32'h3C5A_E187;
  logic [4:0] m = 0;
  logic dec_valid, dec_accept;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dst_addr_filter u_dst_addr_filter (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .byte_vld(byte_vld), .byte_in(byte_in),
    .station_addr(station_addr), .hash_lo(hash_lo), .hash_hi(hash_hi),
    .mode_promisc(m[0]), .mode_all_mcast(m[1]), .mode_hash_mix(m[2]),
    .mode_hash_uni(m[3]), .mode_invert(m[4]),
    .dec_valid(dec_valid), .dec_accept(dec_accept));

  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] r;
    r = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      if (r[0] ^ a[k]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    logic [63:0] tbl;
    logic hit, p, mc;
    tbl = {hash_hi, hash_lo};
    hit = tbl[ref_bin(a)];
    mc  = a[0];
    if (a == 48'hFFFF_FFFF_FFFF || m[0]) return 1'b1;
    if (mc) p = m[1] | ((m[2] | m[3]) & hit);
    else    p = m[3] ? hit : (a == station_addr);
    return p ^ m[4];
  endfunction

  function automatic string tag_for(input logic [47:0] a);
    if (a == 48'hFFFF_FFFF_FFFF) return "R5";
    if (m[0]) return "R6";
    if (m[4]) return "R11";
    if (a[0] && m[1]) return "R7";
    if (m[3]) return "R10";
    if (m[2]) return "R8";
    return "R9";
  endfunction

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic send(input logic [47:0] a);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      frm_start = (i == 0);
      byte_vld  = 1'b1;
      byte_in   = a[8*i +: 8];
    end
    @(negedge clk);
    frm_start = 0; byte_vld = 0;
  endtask

  task automatic send_check(input logic [47:0] a, input string tag);
    send(a);
    chk(dec_valid, 1'b1, tag);
    chk(dec_accept, ref_accept(a), tag);
    @(negedge clk);
    chk(dec_valid, 1'b0, "R3");
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] addrs [5];
    repeat (3) @(negedge clk);
    chk(dec_valid, 1'b0, "R1");
    rst_n = 1;
    @(negedge clk);
    chk(dec_valid, 1'b0, "R1");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); byte_vld = 1; byte_in = 8'hFF;
    end
    @(negedge clk); byte_vld = 0;
    for (int i = 0; i < 3; i++) begin
      chk(dec_valid, 1'b0, "R1");
      @(negedge clk);
    end

    addrs[0] = station_addr;
    addrs[1] = station_addr ^ 48'h00_00_00_10_00_00;
    addrs[2] = 48'h11_22_33_00_5E_01;
    addrs[3] = 48'hC4_81_7A_02_9B_33;
    addrs[4] = 48'hFFFF_FFFF_FFFF;
    for (int mm = 0; mm < 32; mm++) begin
      m = mm[4:0];
      for (int j = 0; j < 5; j++) send_check(addrs[j], tag_for(addrs[j]));
    end

    m = 5'b00100;
    for (int k = 0; k < 64; k++) begin
      logic [47:0] a;
      logic [63:0] t;
      a = 48'h12_34_56_78_9A_01 ^ (48'(k) << 17) ^ (48'(k) << 9);
      t = 64'd1 << ref_bin(a);
      {hash_hi, hash_lo} = t;
      send(a);
      chk(dec_valid & dec_accept, 1'b1, "R2");
      {hash_hi, hash_lo} = ~t;
      send(a);
      chk(dec_valid, 1'b1, "R2");
      chk(dec_accept, 1'b0, "R2");
    end

    hash_lo = 32'hA5C3_0F96; hash_hi = 32'h3C5A_E187;
    m = 5'b00000;
    send(station_addr);
    chk(dec_accept, 1'b1, "R9");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); byte_vld = 1; byte_in = 8'hFF;
      chk(dec_valid, 1'b0, "R3");
    end
    @(negedge clk); byte_vld = 0;
    chk(dec_valid, 1'b0, "R3");

    for (int i = 0; i < 3; i++) begin
      @(negedge clk); frm_start = (i == 0); byte_vld = 1; byte_in = 8'h5A;
    end
    send_check(station_addr, "R4");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); frm_start = (i == 0); byte_vld = 1; byte_in = station_addr[8*i +: 8];
    end
    send_check(48'h10_20_30_40_50_60, "R4");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule